// File: doc/BRIEF.md
# Pseudo-Carry Lookahead Adder

A purely combinational adder of two `WIDTH`-bit operands with a carry-in. It produces a `WIDTH`-bit sum and a carry-out. The lookahead network does not carry the true carry. It carries a pseudo-carry `h_i = c_i | c_(i-1)`. Because `h_i` ignores the transfer signal of the bit just below it, each term of the unrolled lookahead is one literal shorter than the term for the real carry.

Each bit first forms a generate `g = x & y`, a transfer `t = x | y` and a half-sum `p = x ^ y`. Four-bit lookahead groups evaluate `h` for their four positions with fully unrolled two-level equations. Each group takes as inputs the pseudo-carry entering it and the transfer signal of the bit just below it. Groups are chained from the least significant end. The chain starts from `cin` with an implied transfer of one, so `h_1 = g_0 | cin`.

Only the sum stage recovers the real carry, as `c_i = h_i & t_(i-1)`, with `c_0 = cin`. It then forms `z_i = p_i ^ c_i`. The carry-out is `h_WIDTH & t_(WIDTH-1)`. `WIDTH` must be a multiple of 4. The adder is used as a drop-in fast adder in a datapath that registers its result elsewhere.

Top module: `ling_adder`

## Requirements
- R1: `sum_o` equals bits WIDTH-1..0 of the arithmetic value `a_i + b_i + cin_i`, for every operand pair and both carry-in values.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: An all-ones operand plus one (either `b_i = 1`, or `b_i = 0` with `cin_i = 1`) gives `sum_o = 0` and `cout_o = 1`, so the carry crosses every 4-bit group.
- R4: Inside the block, every real carry that the sum stage recovers from the pseudo-carry equals the ripple carry `g_(i-1) | (c_(i-1) & p_(i-1))`. Every pseudo-carry is 1 wherever the generate of the bit below it is 1.
- R5: With `b_i = ~a_i`, every bit transfers but none generates. `cin_i = 0` then gives `sum_o` all ones with `cout_o = 0`, and `cin_i = 1` gives `sum_o = 0` with `cout_o = 1`.
- R6: With both operands zero, `sum_o` equals `cin_i` zero-extended and `cout_o = 0`.
- R7: Swapping `a_i` and `b_i` leaves `sum_o` and `cout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
An 8-bit copy is driven with every operand pair and both carry-in values. This separates a wrong group equation at any position and any boundary between groups from a correct one. A 32-bit copy receives seeded random operands. It also receives directed patterns: all-ones plus one, which exposes a break anywhere in the chain of pseudo-carries between groups, and complementary operands, which transfer everywhere but generate nowhere and so test whether `cin` reaches the top through transfer terms alone. Zero operands and swapped operands show that the carry-in is injected only at bit 0 and that the group terms are symmetric in the two operands.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int unsigned GROUP_W = 4;
endpackage

// File: rtl/ling_bit_pg.sv
module ling_bit_pg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] t_o,
  output logic [WIDTH-1:0] p_o
);
  assign g_o = a_i & b_i;
  assign t_o = a_i | b_i;
  assign p_o = a_i ^ b_i;
endmodule

// File: rtl/ling_h_group.sv
// One 4-bit lookahead group: h for positions b+1..b+4 from h_b and t_(b-1).
module ling_h_group
  import ling_pkg::*;
(
  input  logic               h_in_i,
  input  logic               t_below_i,
  input  logic [GROUP_W-1:0] g_i,
  input  logic [GROUP_W-1:0] t_i,
  output logic [GROUP_W-1:0] h_o
);
  logic h_pass;
  assign h_pass = h_in_i & t_below_i;

  assign h_o[0] = g_i[0] | h_pass;
  assign h_o[1] = g_i[1] | g_i[0] | (h_pass & t_i[0]);
  assign h_o[2] = g_i[2] | g_i[1] | (g_i[0] & t_i[1])
                | (h_pass & t_i[0] & t_i[1]);
  assign h_o[3] = g_i[3] | g_i[2] | (g_i[1] & t_i[2]) | (g_i[0] & t_i[1] & t_i[2])
                | (h_pass & t_i[0] & t_i[1] & t_i[2]);

  always_comb begin
    for (int k = 0; k < GROUP_W; k++) begin
      AST_H_FLOOR: assert (!g_i[k] || h_o[k]) else $error("h below generate"); // R4
    end
  end
endmodule

// File: rtl/ling_sum.sv
// Recovers true carries from pseudo-carries and forms the sum.
module ling_sum #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             cin_i,
  input  logic [WIDTH-1:0] h_i,   // h_i[k] is pseudo-carry into bit k+1
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] t_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;

  assign c[0] = cin_i;
  for (genvar k = 1; k <= WIDTH; k++) begin : g_rec
    assign c[k] = h_i[k-1] & t_i[k-1];
  end

  assign sum_o  = p_i ^ c[WIDTH-1:0];
  assign cout_o = c[WIDTH];

  always_comb begin
    for (int k = 1; k <= WIDTH; k++) begin
      AST_CARRY_RIPPLE: assert (c[k] == (g_i[k-1] | (c[k-1] & p_i[k-1])))
        else $error("recovered carry %0d wrong", k); // R4
    end
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NUM_GRP = WIDTH / GROUP_W;

  logic [WIDTH-1:0] g, t, p, h;
  logic [NUM_GRP-1:0] grp_h_in, grp_t_below;

  ling_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i(a_i), .b_i(b_i), .g_o(g), .t_o(t), .p_o(p)
  );

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp
    if (j == 0) begin : g_first
      assign grp_h_in[j]    = cin_i;  // h_0 = cin with implied transfer of one
      assign grp_t_below[j] = 1'b1;
    end else begin : g_next
      assign grp_h_in[j]    = h[j*GROUP_W-1];
      assign grp_t_below[j] = t[j*GROUP_W-1];
    end
    ling_h_group u_grp (
      .h_in_i   (grp_h_in[j]),
      .t_below_i(grp_t_below[j]),
      .g_i      (g[j*GROUP_W +: GROUP_W]),
      .t_i      (t[j*GROUP_W +: GROUP_W]),
      .h_o      (h[j*GROUP_W +: GROUP_W])
    );
  end

  ling_sum #(.WIDTH(WIDTH)) u_sum (
    .cin_i(cin_i), .h_i(h), .g_i(g), .t_i(t), .p_i(p),
    .sum_o(sum_o), .cout_o(cout_o)
  );

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_EXACT: assert (sum_o == ref_total[WIDTH-1:0]) else $error("sum mismatch"); // R1
    AST_COUT_EXACT: assert (cout_o == ref_total[WIDTH]) else $error("cout mismatch"); // R2
    AST_ZERO_OPS: assert (!(a_i == '0 && b_i == '0) ||
                          (sum_o == {{(WIDTH-1){1'b0}}, cin_i} && !cout_o))
      else $error("zero operands"); // R6
  end
endmodule

// File: tb/ling_adder_bench.sv
module ling_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 60000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a, b, sum;
  logic        cin, cout;
  logic [7:0]  a8, b8, sum8;
  logic        cin8, cout8;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  ling_adder #(.WIDTH(32)) u_ling_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );
  ling_adder #(.WIDTH(8)) u_ling_adder_k8 (
    .a_i(a8), .b_i(b8), .cin_i(cin8), .sum_o(sum8), .cout_o(cout8)
  );

  function automatic logic [32:0] ref32(logic [31:0] x, logic [31:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  function automatic logic [8:0] ref8(logic [7:0] x, logic [7:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {8'd0, c};
  endfunction

  task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic drive32(logic [31:0] x, logic [31:0] y, logic c);
    a = x; b = y; cin = c;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [32:0] r, keep;
    logic [31:0] x, y;
    a = '0; b = '0; cin = 1'b0; a8 = '0; b8 = '0; cin8 = 1'b0;
    void'($urandom(32'd2024));
    #1;
    // reset-like idle state
    chk("R6 idle", {cout, sum}, 33'd0);

    // R6: zero operands
    drive32('0, '0, 1'b1);
    chk("R6 zero cin1", {cout, sum}, 33'd1);
    drive32('0, '0, 1'b0);
    chk("R6 zero cin0", {cout, sum}, 33'd0);

    // R3: full-length carry chain
    drive32('1, 32'd1, 1'b0);
    chk("R3 ones+1", {cout, sum}, {1'b1, 32'd0});
    drive32('1, '0, 1'b1);
    chk("R3 ones+cin", {cout, sum}, {1'b1, 32'd0});
    drive32(32'h0000_0FFF, 32'd1, 1'b0);
    chk("R3 group boundary", {cout, sum}, 33'h0_0000_1000);

    // R5: transfer everywhere, generate nowhere
    drive32(32'hA5C3_0F96, ~32'hA5C3_0F96, 1'b0);
    chk("R5 cin0", {cout, sum}, {1'b0, 32'hFFFF_FFFF});
    drive32(32'hA5C3_0F96, ~32'hA5C3_0F96, 1'b1);
    chk("R5 cin1", {cout, sum}, {1'b1, 32'd0});

    // R1/R2 directed extremes
    drive32('1, '1, 1'b1);
    chk("R1 R2 max", {cout, sum}, {1'b1, 32'hFFFF_FFFF});
    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R2 msb only", {cout, sum}, {1'b1, 32'd0});

    // R1/R2 random, R7 swap
    for (int n = 0; n < 2000; n++) begin
      x = $urandom; y = $urandom;
      drive32(x, y, 1'($urandom));
      r = ref32(x, y, cin);
      chk("R1 R2 random", {cout, sum}, r);
      keep = {cout, sum};
      drive32(y, x, cin);
      chk("R7 swap", {cout, sum}, keep);
    end

    // R1/R2 exhaustive at width 8
    for (int v = 0; v < (1 << 17); v++) begin
      logic [8:0] e;
      {cin8, a8, b8} = 17'(v);
      #1;
      e = ref8(a8, b8, cin8);
      checks++;
      if ({cout8, sum8} !== e) begin
        fails++;
        $display("FAIL R1 R2 k8 a=%h b=%h cin=%b actual=%h expected=%h",
                 a8, b8, cin8, {cout8, sum8}, e);
      end
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end
endmodule